// File: doc/BRIEF.md
# Multi-Cycle Load/Store Processor Core

This block is a small 32-bit processor core that runs one instruction at a time, with no pipelining. Each instruction moves through a fixed run of one-clock phases: fetch, decode with register read, execute or address generation, memory access with branch completion, and an optional write-back. Every phase leaves its result in a dedicated latch: instruction word, next sequential PC, two operands, extended immediate, ALU result, branch condition, and load data. The next phase reads only those latches. The core holds 32 general registers.

The core drives one instruction memory port and one data memory port. Neither port has a handshake. Both memories must return read data combinationally in the same cycle the address is presented. The data memory must accept a write on the clock edge that ends a cycle with the write strobe high. Neither memory can apply back-pressure: the core never waits, and every phase lasts exactly one clock. Reset is synchronous and active high.

Instruction fields sit in the usual positions: opcode in bits 31:26, first source register in 25:21, second source or immediate destination register in 20:16, register-form destination in 15:11, and function code in 5:0. The 16-bit immediate is always sign-extended. A register-form word with a nonzero value in bits 10:6, an unknown function code or an unknown opcode runs as a four-clock no-op.

Top module: `mc_risc_core`

## Requirements
- R1: A clock edge with `rst` high sets the PC to `RESET_PC` (default 0) and puts the core in the fetch phase. While reset is held, `imem_addr` equals `RESET_PC` and `dmem_we` is low.
- R2: The fetch phase reads the instruction at `imem_addr`, which equals the PC. The PC advances, by 4 or to a branch target, only on the edge that ends the memory phase.
- R3: Register-form instructions (opcode 0x00) combine the two source registers and write the result to the register in bits 15:11. The function codes are 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR and 0x2A signed set-less-than, which gives 1 or 0.
- R4: Immediate-form instructions write to the register in bits 20:16. They combine the first source register with the sign-extended immediate: opcode 0x08 add, 0x09 subtract, 0x0A signed set-less-than, 0x0C AND, 0x0D OR.
- R5: Load word (0x23) and store word (0x2B) use the address first-source-register plus sign-extended immediate. A load writes the word read to the register in bits 20:16. A store drives that address on `dmem_addr` and the register in bits 20:16 on `dmem_wdata`.
- R6: The branch (opcode 0x04) is taken when the first source register is zero. A taken branch sets the PC to PC + 4 + (immediate × 4), and backward offsets are allowed. Otherwise the PC becomes PC + 4.
- R7: Stores, branches and no-ops take 4 clocks. Register-form, immediate-form and load instructions take 5. A store raises `dmem_we` in its fourth clock.
- R8: Register 0 always reads as zero. A write aimed at it has no effect.
- R9: `dmem_we` is high for exactly one clock per store and never at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one clock per store |
| dmem_rdata | input | 32 | Word at `dmem_addr`, same cycle |

## Verification
The bench builds the core with its default parameters: a reset PC of zero and a 32-entry register file. A 64-word instruction memory and a 64-word data memory are enough to hold a program that reaches every ALU operation in both forms, a load, a store with a negative offset, a write aimed at register 0, a forward taken branch, a not-taken branch, and a backward branch used as a halt loop. Each store pulse is checked for address, data and the exact clock it appears in, counted from reset. Because of the timing check, a wrong phase count or a wrong branch path shows up even when the stored values happen to agree. Reset is applied again in the middle of an instruction to show that the next run restarts cleanly.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;
  localparam int WORD_W      = 32;
  localparam int REG_NUM     = 32;
  localparam int REG_AW      = 5;
  localparam int IMM_W       = 16;
  localparam int INSTR_BYTES = 4;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQZ  = 6'h04;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SUBI  = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB
  } phase_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_t;

  typedef enum logic [2:0] {
    CL_RR, CL_RI, CL_LOAD, CL_STORE, CL_BRANCH, CL_NOP
  } iclass_t;

  typedef struct packed {
    iclass_t           cls;
    alu_op_t           op;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] dest;
    logic              wb_en;
    logic [IMM_W-1:0]  imm;
  } decode_t;
endpackage

// File: rtl/mc_decoder.sv
module mc_decoder
  import mc_core_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output decode_t           dec
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] shamt;

  always_comb begin
    opc   = instr[31:26];
    fn    = instr[5:0];
    shamt = instr[10:6];

    dec.rs    = instr[25:21];
    dec.rt    = instr[20:16];
    dec.imm   = instr[15:0];
    dec.dest  = instr[20:16];
    dec.cls   = CL_NOP;
    dec.op    = ALU_ADD;
    dec.wb_en = 1'b0;

    case (opc)
      OPC_RTYPE: begin
        dec.dest = instr[15:11];
        if (shamt == '0) begin
          dec.cls   = CL_RR;
          dec.wb_en = 1'b1;
          case (fn)
            FN_ADD:  dec.op = ALU_ADD;
            FN_SUB:  dec.op = ALU_SUB;
            FN_AND:  dec.op = ALU_AND;
            FN_OR:   dec.op = ALU_OR;
            FN_SLT:  dec.op = ALU_SLT;
            default: begin
              dec.cls   = CL_NOP;
              dec.wb_en = 1'b0;
            end
          endcase
        end
      end
      OPC_ADDI: begin dec.cls = CL_RI; dec.wb_en = 1'b1; dec.op = ALU_ADD; end
      OPC_SUBI: begin dec.cls = CL_RI; dec.wb_en = 1'b1; dec.op = ALU_SUB; end
      OPC_SLTI: begin dec.cls = CL_RI; dec.wb_en = 1'b1; dec.op = ALU_SLT; end
      OPC_ANDI: begin dec.cls = CL_RI; dec.wb_en = 1'b1; dec.op = ALU_AND; end
      OPC_ORI:  begin dec.cls = CL_RI; dec.wb_en = 1'b1; dec.op = ALU_OR;  end
      OPC_LW:   begin dec.cls = CL_LOAD; dec.wb_en = 1'b1; end
      OPC_SW:   dec.cls = CL_STORE;
      OPC_BEQZ: dec.cls = CL_BRANCH;
      default:  dec.cls = CL_NOP;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_t      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NUM = 32,
  parameter int DW  = 32,
  localparam int AW = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] rda,
  output logic [DW-1:0] rdb
);
  logic [DW-1:0] regs [NUM];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rda = (ra == '0) ? '0 : regs[ra];
  assign rdb = (rb == '0) ? '0 : regs[rb];

  // R8
  wb_update_chk: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mc_core_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  iclass_t cls,
  output phase_t  phase
);
  logic short_instr;
  assign short_instr = (cls == CL_STORE) || (cls == CL_BRANCH) || (cls == CL_NOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
    end else begin
      case (phase)
        PH_FETCH:  phase <= PH_DECODE;
        PH_DECODE: phase <= PH_EXEC;
        PH_EXEC:   phase <= PH_MEM;
        PH_MEM:    phase <= short_instr ? PH_FETCH : PH_WB;
        PH_WB:     phase <= PH_FETCH;
        default:   phase <= PH_FETCH;
      endcase
    end
  end

  // R7
  short_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM && (cls == CL_STORE || cls == CL_BRANCH)) |=> (phase == PH_FETCH));

  // R7
  long_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM && (cls == CL_RR || cls == CL_RI || cls == CL_LOAD)) |=> (phase == PH_WB));
endmodule

// File: rtl/mc_risc_core.sv
module mc_risc_core
  import mc_core_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] imem_addr,
  input  logic [WORD_W-1:0] imem_rdata,
  output logic [WORD_W-1:0] dmem_addr,
  output logic [WORD_W-1:0] dmem_wdata,
  output logic              dmem_we,
  input  logic [WORD_W-1:0] dmem_rdata
);
  localparam logic [WORD_W-1:0] PC_STEP = WORD_W'(INSTR_BYTES);
  localparam int EXT_W = WORD_W - IMM_W;

  phase_t phase;
  decode_t dec;

  logic [WORD_W-1:0] pc_q, ir_q, npc_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic              cond_q;

  logic [WORD_W-1:0] rd_a, rd_b, imm_ext;
  logic [WORD_W-1:0] opnd_a, opnd_b, alu_y;
  logic [WORD_W-1:0] wb_data;
  logic              wb_we;
  logic              take_branch;

  mc_decoder u_dec (
    .instr (ir_q),
    .dec   (dec)
  );

  mc_sequencer u_seq (
    .clk   (clk),
    .rst   (rst),
    .cls   (dec.cls),
    .phase (phase)
  );

  mc_regfile #(.NUM(REG_NUM), .DW(WORD_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_we),
    .waddr (dec.dest),
    .wdata (wb_data),
    .ra    (dec.rs),
    .rb    (dec.rt),
    .rda   (rd_a),
    .rdb   (rd_b)
  );

  mc_alu #(.W(WORD_W)) u_alu (
    .op (dec.op),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (alu_y)
  );

  assign imm_ext = {{EXT_W{dec.imm[IMM_W-1]}}, dec.imm};

  always_comb begin
    opnd_a = a_q;
    opnd_b = b_q;
    case (dec.cls)
      CL_RI, CL_LOAD, CL_STORE: opnd_b = imm_q;
      CL_BRANCH: begin
        opnd_a = npc_q;
        opnd_b = imm_q << 2;
      end
      default: ;
    endcase
  end

  assign take_branch = (dec.cls == CL_BRANCH) && cond_q;
  assign wb_we       = (phase == PH_WB) && dec.wb_en;
  assign wb_data     = (dec.cls == CL_LOAD) ? lmd_q : alu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      ir_q   <= '0;
      npc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      cond_q <= 1'b0;
      lmd_q  <= '0;
    end else begin
      case (phase)
        PH_FETCH: begin
          ir_q  <= imem_rdata;
          npc_q <= pc_q + PC_STEP;
        end
        PH_DECODE: begin
          a_q   <= rd_a;
          b_q   <= rd_b;
          imm_q <= imm_ext;
        end
        PH_EXEC: begin
          alu_q  <= alu_y;
          cond_q <= (dec.cls == CL_BRANCH) && (a_q == '0);
        end
        PH_MEM: begin
          pc_q <= take_branch ? alu_q : npc_q;
          if (dec.cls == CL_LOAD) lmd_q <= dmem_rdata;
        end
        default: ;
      endcase
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_q;
  assign dmem_wdata = b_q;
  assign dmem_we    = (phase == PH_MEM) && (dec.cls == CL_STORE);

  // R2
  fetch_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH) |=> (ir_q == $past(imem_rdata)));

  // R6
  branch_target_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM && dec.cls == CL_BRANCH && cond_q) |=> (pc_q == $past(alu_q)));

  // R6
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MEM && !(dec.cls == CL_BRANCH && cond_q)) |=> (pc_q == $past(npc_q)));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_MEM) |=> $stable(pc_q));

  // R9
  store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> !dmem_we);

  // R3
  slt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && dec.op == ALU_SLT && (dec.cls == CL_RR || dec.cls == CL_RI))
      |=> (alu_q[WORD_W-1:1] == '0));
endmodule

// File: tb/mc_risc_core_tb.sv
`timescale 1ns/1ps
module mc_risc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  localparam int NVEC = 13;
  localparam logic [31:0] V_ADDR [NVEC] = '{
    32'h40, 32'h44, 32'h48, 32'h4C, 32'h50, 32'h54, 32'h58,
    32'h5C, 32'h64, 32'h68, 32'h6C, 32'h70, 32'h74};
  localparam logic [31:0] V_DATA [NVEC] = '{
    32'h2, 32'h8, 32'h0, 32'hD, 32'h1, 32'h0, 32'h12345679,
    32'h0, 32'hFFFFFFFC, 32'h1, 32'h4, 32'h35, 32'h35};
  localparam int V_CYC [NVEC] = '{
    18, 27, 41, 45, 59, 63, 77, 86, 103, 122, 126, 130, 139};

  always #2.5 clk = ~clk;

  mc_risc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic [31:0] rr(input logic [5:0] fn, input logic [4:0] rd,
                                     input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] rs, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic string vreq(input int i);
    case (i)
      6:       return "R5";
      7:       return "R8";
      8, 9, 10, 11: return "R4";
      12:      return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic next_store(output logic [31:0] a, output logic [31:0] d, output int c);
    do @(negedge clk); while (dmem_we !== 1'b1);
    a = dmem_addr;
    d = dmem_wdata;
    c = cyc;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, d;
    int c;
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'h12345678;
    imem[0]  = ri(6'h08, 1, 0, 16'd5);
    imem[1]  = ri(6'h08, 2, 0, 16'hFFFD);
    imem[2]  = rr(6'h20, 3, 1, 2);
    imem[3]  = ri(6'h2B, 3, 0, 16'h40);
    imem[4]  = rr(6'h22, 4, 1, 2);
    imem[5]  = ri(6'h2B, 4, 0, 16'h44);
    imem[6]  = rr(6'h24, 5, 4, 1);
    imem[7]  = rr(6'h25, 6, 4, 1);
    imem[8]  = ri(6'h2B, 5, 0, 16'h48);
    imem[9]  = ri(6'h2B, 6, 0, 16'h4C);
    imem[10] = rr(6'h2A, 7, 2, 1);
    imem[11] = rr(6'h2A, 8, 1, 2);
    imem[12] = ri(6'h2B, 7, 0, 16'h50);
    imem[13] = ri(6'h2B, 8, 0, 16'h54);
    imem[14] = ri(6'h23, 9, 0, 16'h0);
    imem[15] = ri(6'h08, 10, 9, 16'd1);
    imem[16] = ri(6'h2B, 10, 0, 16'h58);
    imem[17] = ri(6'h08, 0, 0, 16'd7);
    imem[18] = ri(6'h2B, 0, 0, 16'h5C);
    imem[19] = ri(6'h04, 0, 5, 16'd2);
    imem[20] = ri(6'h2B, 1, 0, 16'h60);
    imem[21] = ri(6'h2B, 1, 0, 16'h60);
    imem[22] = ri(6'h04, 0, 1, 16'd5);
    imem[23] = ri(6'h09, 11, 1, 16'd9);
    imem[24] = ri(6'h2B, 11, 0, 16'h64);
    imem[25] = ri(6'h0A, 12, 2, 16'hFFFE);
    imem[26] = ri(6'h0C, 13, 6, 16'h6);
    imem[27] = ri(6'h0D, 14, 1, 16'h30);
    imem[28] = ri(6'h2B, 12, 0, 16'h68);
    imem[29] = ri(6'h2B, 13, 0, 16'h6C);
    imem[30] = ri(6'h2B, 14, 0, 16'h70);
    imem[31] = ri(6'h08, 16, 0, 16'h78);
    imem[32] = ri(6'h2B, 14, 16, 16'hFFFC);
    imem[33] = ri(6'h04, 0, 0, 16'hFFFF);

    // R1: state while reset is held
    repeat (3) @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'h0);
    chk("R1", "we in reset", {31'd0, dmem_we}, 32'h0);
    rst = 1'b0;

    // R2: PC moves only at the end of the memory phase
    repeat (3) @(negedge clk);
    chk("R2", "pc before mem end", imem_addr, 32'h0);
    @(negedge clk);
    chk("R2", "pc after first instr", imem_addr, 32'h4);

    // Vector table walk: every store pulse in order
    for (int i = 0; i < NVEC; i++) begin
      next_store(a, d, c);
      chk((i == 8) ? "R6" : "R5", $sformatf("store %0d addr", i), a, V_ADDR[i]);
      chk(vreq(i), $sformatf("store %0d data", i), d, V_DATA[i]);
      chk("R7", $sformatf("store %0d cycle", i), 32'(c), 32'(V_CYC[i]));
      @(negedge clk);
      chk("R9", $sformatf("store %0d strobe drop", i), {31'd0, dmem_we}, 32'h0);
    end

    // R6: backward branch holds the core in a loop at 0x84; R9: no stray strobe
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk("R6", "halt loop pc", imem_addr, 32'h84);
      chk("R9", "no strobe in loop", {31'd0, dmem_we}, 32'h0);
      @(negedge clk);
    end
    chk("R8", "r0 store kept zero", dmem[23], 32'h0);
    chk("R6", "skipped store absent", dmem[24], 32'h0);

    // R1: reset from the loop, then again in the middle of an instruction
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc after reset", imem_addr, 32'h0);
    rst = 1'b0;
    repeat (22) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc after mid reset", imem_addr, 32'h0);
    chk("R1", "we after mid reset", {31'd0, dmem_we}, 32'h0);
    rst = 1'b0;
    next_store(a, d, c);
    chk("R1", "restart store addr", a, 32'h40);
    chk("R3", "restart store data", d, 32'h2);
    chk("R7", "restart store cycle", 32'(c), 32'd18);

    finish_run();
  end
endmodule